// File: doc/BRIEF.md
# PTP turnaround correction adjuster

This block updates the correctionField of an outgoing peer-delay response so that it carries the time the node took to answer the request. It receives several inputs that an external frame parser and timestamp unit provide:

- the ingress time of the matching request, kept as a short seconds count plus nanoseconds;
- the egress time captured at the start of the response frame, already corrected for latency;
- the original 64-bit correctionField;
- an insertion enable;
- a few header fields.

On a `start` pulse the block works out the turnaround in nanoseconds and converts it to correctionField units, which are 2^-16 ns. It adds the turnaround to the original field with saturation at the largest positive value. It registers the result together with a valid strobe.

The ingress seconds are stored with only `SEC_BITS` bits, so the seconds difference wraps modulo 2^`SEC_BITS`. The response must therefore leave within that many seconds. When the enable is clear, the reserved flag is set or the version does not match, the original field is passed through unchanged. Frame parsing, byte substitution and checksum or FCS work belong to neighbouring logic.

Top module: `ptp_turnaround_adj`

## Requirements
- R1: After reset `cf_valid` is 0 and `cf_out` is 0. `cf_valid` is 1 in exactly the cycle after a cycle in which `start` was sampled high, and `cf_out` carries the result in that same cycle.
- R2: When adjusting, turnaround_ns = secdiff × 1,000,000,000 + nsdiff. If `egr_ns` < `ing_ns`, nsdiff gets 1,000,000,000 added and secdiff is reduced by one, modulo 16. The value added to `cf_in` is turnaround_ns × 65536.
- R3: secdiff = (`egr_sec[3:0]` − `ing_sec`) mod 16. Higher bits of `egr_sec` have no effect.
- R4: For a non-negative `cf_in` whose adjusted value would exceed 0x7FFFFFFFFFFFFFFF, `cf_out` is 0x7FFFFFFFFFFFFFFF. A result that lands exactly on that value is not altered.
- R5: A `cf_in` equal to 0x7FFFFFFFFFFFFFFF is output unchanged.
- R6: With `ins_en` = 0, `cf_out` equals `cf_in`.
- R7: With bit 7 of `hdr_rsvd` = 1, `cf_out` equals `cf_in`. Bits 6..0 of `hdr_rsvd` have no effect.
- R8: Adjustment happens only when `hdr_version[3:0]` = 2. Any other value, including 1, gives `cf_out` = `cf_in`. `hdr_version[7:4]` has no effect.
- R9: `hdr_domain` and `hdr_alt_master` have no effect on `cf_out`.
- R10: A negative (two's complement) `cf_in` receives the plain sum `cf_in` + turnaround without clamping.
- R11: `cf_out` holds its value while `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Compute request; all data inputs are sampled with it |
| ins_en | input | 1 | Turnaround insertion enable |
| hdr_rsvd | input | 8 | Header reserved byte; bit 7 set blocks adjustment |
| hdr_version | input | 8 | Header version byte; low nibble must be 2 |
| hdr_domain | input | 8 | Domain number, ignored |
| hdr_alt_master | input | 1 | Alternate-master flag, ignored |
| ing_sec | input | SEC_BITS (4) | Stored request ingress seconds, truncated |
| ing_ns | input | NS_W (30) | Stored request ingress nanoseconds |
| egr_sec | input | EGR_SEC_W (32) | Response egress seconds |
| egr_ns | input | NS_W (30) | Response egress nanoseconds |
| cf_in | input | 64 | Original correctionField |
| cf_out | output | 64 | Adjusted or passed-through correctionField |
| cf_valid | output | 1 | Result strobe, one cycle after `start` |

## Verification
The assertions assume that both nanosecond inputs are below 1,000,000,000 and that all data inputs are stable in the cycle `start` is high. Under those assumptions the output never drops below the signed input and never turns a non-negative field negative. The stimulus drives only legal nanosecond values, such as 0, 999,999,999 and mid-range values, and sets every input a half cycle before the sampling edge. The seconds sweep covers all 256 pairs of stored and egress seconds, so wrapped and borrowed differences are all legal under the 16-second window.

// File: rtl/ptp_turnaround_adj.sv
module ptp_turnaround_adj #(
  parameter int SEC_BITS  = 4,
  parameter int NS_W      = 30,
  parameter int EGR_SEC_W = 32,
  parameter int CF_W      = 64,
  parameter int FRAC_BITS = 16,
  parameter logic [3:0] VERSION = 4'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 ins_en,
  input  logic [7:0]           hdr_rsvd,
  input  logic [7:0]           hdr_version,
  input  logic [7:0]           hdr_domain,
  input  logic                 hdr_alt_master,
  input  logic [SEC_BITS-1:0]  ing_sec,
  input  logic [NS_W-1:0]      ing_ns,
  input  logic [EGR_SEC_W-1:0] egr_sec,
  input  logic [NS_W-1:0]      egr_ns,
  input  logic [CF_W-1:0]      cf_in,
  output logic [CF_W-1:0]      cf_out,
  output logic                 cf_valid
);

  localparam int TN_W = SEC_BITS + NS_W + 1;
  localparam int TC_W = TN_W + FRAC_BITS;
  localparam logic [NS_W:0]     NS_SEC_N = (NS_W+1)'(1000000000);
  localparam logic [TN_W-1:0]   NS_SEC_T = TN_W'(1000000000);
  localparam logic [CF_W-1:0]   CF_MAX   = {1'b0, {(CF_W-1){1'b1}}};

  logic                 gate;
  logic [SEC_BITS-1:0]  sec_raw, sec_d;
  logic [NS_W:0]        ns_raw, ns_fix;
  logic                 borrow;
  logic [TN_W-1:0]      turn_ns;
  logic [TC_W-1:0]      turn_cf;
  logic [CF_W:0]        sum;
  logic                 sat;
  logic [CF_W-1:0]      result;
  logic                 hdr_unused;

  assign hdr_unused = ^{hdr_rsvd[6:0], hdr_version[7:4], hdr_domain, hdr_alt_master,
                        egr_sec[EGR_SEC_W-1:SEC_BITS]};

  assign gate = ins_en && !hdr_rsvd[7] && (hdr_version[3:0] == VERSION);

  assign sec_raw = egr_sec[SEC_BITS-1:0] - ing_sec;
  assign ns_raw  = {1'b0, egr_ns} - {1'b0, ing_ns};
  assign borrow  = ns_raw[NS_W];
  assign sec_d   = sec_raw - SEC_BITS'(borrow);
  assign ns_fix  = borrow ? ns_raw + NS_SEC_N : ns_raw;

  assign turn_ns = TN_W'(sec_d) * NS_SEC_T + TN_W'(ns_fix[NS_W-1:0]);
  assign turn_cf = {turn_ns, {FRAC_BITS{1'b0}}};

  assign sum = {1'b0, cf_in} + (CF_W+1)'(turn_cf);
  assign sat = !cf_in[CF_W-1] && sum[CF_W-1];

  always_comb begin
    if (!gate || cf_in == CF_MAX) result = cf_in;
    else if (sat)                 result = CF_MAX;
    else                          result = sum[CF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_out   <= '0;
      cf_valid <= 1'b0;
    end else begin
      cf_valid <= start;
      if (start) cf_out <= result;
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cf_valid); // R1
  AST_NO_VALID_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !cf_valid); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid && !$past(cf_in[CF_W-1]) |-> !cf_out[CF_W-1]); // R4
  AST_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid |-> $signed(cf_out) >= $signed($past(cf_in))); // R2
  AST_MAX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid && $past(cf_in) == CF_MAX |-> cf_out == CF_MAX); // R5
  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid && !$past(ins_en) |-> cf_out == $past(cf_in)); // R6
  AST_RSVD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid && $past(hdr_rsvd[7]) |-> cf_out == $past(cf_in)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cf_out)); // R11

endmodule

// File: tb/ptp_turnaround_adj_test.sv
module ptp_turnaround_adj_test;

  localparam longint unsigned MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam longint unsigned NSEC = 64'd1000000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ins_en = 1'b1;
  logic [7:0]  hdr_rsvd = 8'h00;
  logic [7:0]  hdr_version = 8'h02;
  logic [7:0]  hdr_domain = 8'h00;
  logic        hdr_alt_master = 1'b0;
  logic [3:0]  ing_sec = '0;
  logic [29:0] ing_ns = '0;
  logic [31:0] egr_sec = '0;
  logic [29:0] egr_ns = '0;
  logic [63:0] cf_in = '0;
  logic [63:0] cf_out;
  logic        cf_valid;

  int checks = 0;
  int fails = 0;

  ptp_turnaround_adj uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ins_en(ins_en),
    .hdr_rsvd(hdr_rsvd), .hdr_version(hdr_version), .hdr_domain(hdr_domain),
    .hdr_alt_master(hdr_alt_master), .ing_sec(ing_sec), .ing_ns(ing_ns),
    .egr_sec(egr_sec), .egr_ns(egr_ns), .cf_in(cf_in),
    .cf_out(cf_out), .cf_valid(cf_valid)
  );

  always #10 clk = ~clk;

  function automatic longint unsigned expect_cf();
    longint unsigned s, n, t;
    if (!ins_en || hdr_rsvd[7] || hdr_version[3:0] != 4'd2) return cf_in;
    if (cf_in == MAXV) return cf_in;
    s = longint'((egr_sec[3:0] - ing_sec) & 4'hF);
    if (egr_ns < ing_ns) begin
      n = NSEC + egr_ns - ing_ns;
      s = (s + 15) % 16;
    end else n = longint'(egr_ns - ing_ns);
    t = (s * NSEC + n) * 65536;
    if (cf_in[63]) return cf_in + t;
    if (cf_in > MAXV - t) return MAXV;
    return cf_in + t;
  endfunction

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input string req);
    longint unsigned e;
    e = expect_cf();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({req, " valid"}, longint'(cf_valid), 1);
    check(req, cf_out, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [29:0] ins [5] = '{30'd0, 30'd100, 30'd999999999, 30'd5000, 30'd0};
    logic [29:0] egs [5] = '{30'd0, 30'd5000, 30'd0, 30'd100, 30'd999999999};
    longint unsigned cfs [4] = '{64'd0, 64'd12345, 64'hFFFF_FFFF_0000_0000, 64'h7FFF_F000_0000_0000};
    logic [63:0] held;

    repeat (3) @(negedge clk);
    check("R1 reset valid", longint'(cf_valid), 0);
    check("R1 reset out", cf_out, 0);
    rst_n = 1'b1;

    // R2 R3 R10 R9: full seconds sweep with borrow patterns
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int k = 0; k < 5; k++) begin
          ing_sec = 4'(i);
          egr_sec = {28'(i * 7 + j * 3 + k), 4'(j)};
          ing_ns = ins[k]; egr_ns = egs[k];
          cf_in = cfs[(i + j + k) % 4];
          hdr_domain = 8'(i * 16 + j);
          hdr_alt_master = 1'((i + k) & 1);
          hdr_rsvd = {1'b0, 7'(j * 5 + k)};
          fire("R2 R3 R9 R10 sweep");
        end

    // R8 high nibble ignored
    ing_sec = 4'd3; egr_sec = 32'd5; ing_ns = 30'd10; egr_ns = 30'd20; cf_in = 64'd7;
    hdr_version = 8'h12; fire("R8 high nibble");
    hdr_version = 8'h01; fire("R8 version 1");
    hdr_version = 8'h03; fire("R8 version 3");
    hdr_version = 8'h02;

    ins_en = 1'b0; fire("R6 disabled");
    ins_en = 1'b1;
    hdr_rsvd = 8'h80; fire("R7 reserved bit");
    hdr_rsvd = 8'h7F; fire("R7 low reserved bits");
    hdr_rsvd = 8'h00;

    // R4 boundary: 10 ns turnaround
    ing_sec = 4'd0; egr_sec = 32'd0; ing_ns = 30'd0; egr_ns = 30'd10;
    cf_in = MAXV - 64'd655360; fire("R4 exact max");
    check("R4 exact max value", cf_out, MAXV);
    cf_in = MAXV - 64'd655359; fire("R4 clamp");
    check("R4 clamp value", cf_out, MAXV);
    egr_sec = 32'd15; cf_in = 64'h7000_0000_0000_0000; fire("R4 large turnaround");

    cf_in = MAXV; fire("R5 max kept");
    check("R5 max value", cf_out, MAXV);

    cf_in = 64'hFFFF_FFFF_FFFF_FFFF; egr_sec = 32'd2; fire("R10 negative");

    // R11 hold
    held = cf_out;
    cf_in = 64'd99;
    @(negedge clk);
    check("R11 hold valid", longint'(cf_valid), 0);
    check("R11 hold out", cf_out, held);
    @(negedge clk);
    check("R11 hold out 2", cf_out, held);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule